// File: doc/BRIEF.md
# Serial Management Responder Endpoint

This block is the responder end of a two-wire serial management link, as found on the device side of an Ethernet physical-layer management port. The link controller drives a management clock and a shared data line. The responder has a 32-entry by 16-bit register file. It answers read and write frames only when the frame's device address equals the 5-bit value on its strap pins. The data line is split into a sampled input, a driven value and an output enable, so the three-state pad stays outside the block.

The block runs on a fast local clock, at least eight times the management clock rate. It brings the management clock and the data line into that domain through a short synchronizer. Every action happens on the detected rising edge of the management clock. At that edge the block samples the line, and its own driven value and enable change within three local cycles, so the value is stable before the next rising edge. A local register port lets the logic around the endpoint read any entry and write entries too. A management write commits ahead of a local write to the same entry in the same cycle.

Top module: `mdio_slave`

## Requirements
- R1: A frame is accepted only after at least 32 consecutive 1 bits sampled on rising management-clock edges. A 0 seen before 32 ones have been counted restarts the count from zero.
- R2: After the preamble, the start field must be 0 then 1. A 0 in its second bit returns the block to preamble hunting, and the frame has no effect.
- R3: The opcode (the two bits after the start field, first bit first) selects write for 01 and read for 10. The codes 00 and 11 abandon the frame with no write and no drive.
- R4: The 5-bit device address follows the opcode, and the 5-bit register address follows the device address, each sent most significant bit first. If the device address differs from `phy_addr_strap`, the frame causes no write, and `mdio_oe` stays low for the whole frame.
- R5: On a matching read, `mdio_oe` is low during the first turnaround bit, so the line reads 1 through the pull-up. During the second turnaround bit the block drives 0.
- R6: On a matching read, the 16 data bits of the addressed entry are driven most significant bit first. Each bit changes within 3 local clock cycles after a rising management-clock edge. `mdio_oe` drops after the rising edge that ends the last data bit.
- R7: On a write, the two turnaround bits are ignored and `mdio_oe` stays low. The 16 data bits, most significant bit first, are committed to the addressed entry only after the 16th bit is sampled.
- R8: `loc_rdata` shows the entry selected by `loc_addr` without a clock. `loc_we` writes `loc_wdata` to that entry on the next clock. If a management commit and a local write hit the same entry in the same cycle, the management data is kept.
- R9: After reset, every entry reads 0 and `mdio_oe` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Local clock, at least 8x the management clock rate |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mdc | input | 1 | Management clock from the link controller |
| mdio_in | input | 1 | Sampled level of the shared data line |
| mdio_out | output | 1 | Value driven onto the data line when enabled |
| mdio_oe | output | 1 | Output enable for the data line pad |
| phy_addr_strap | input | 5 | Device address this endpoint answers to |
| loc_addr | input | 5 | Local port entry select |
| loc_we | input | 1 | Local port write strobe |
| loc_wdata | input | 16 | Local port write data |
| loc_rdata | output | 16 | Local port read data |

## Verification
A wrong frame state shows up quickly at the ports. A mis-counted field shifts read data by one or more bit positions on the line, and it moves the turnaround low to the wrong bit, within the same frame. A preamble counter that accepts too early, or that ignores an intervening 0, shows up as a register change after a short or broken preamble. The bench reads this through the local port right after the frame. Loss of address filtering or opcode decoding shows up as any cycle with the output enable high during a frame that should have been ignored. A wrong write priority shows up as the local value surviving in the entry after the collision cycle.

// File: rtl/mdio_slv_pkg.sv
package mdio_slv_pkg;

  typedef enum logic [2:0] {
    S_PRE,
    S_SOF,
    S_CMD,
    S_RTA,
    S_RDAT,
    S_RLAST,
    S_WTA,
    S_WDAT
  } mdio_st_e;

  localparam logic [1:0] OP_WR = 2'b01;
  localparam logic [1:0] OP_RD = 2'b10;

endpackage

// File: rtl/mdio_sampler.sv
module mdio_sampler #(
  parameter int SYNC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mdc,
  input  logic mdio_in,
  output logic rise,
  output logic bit_q
);

  logic [SYNC:0]   mdc_q;
  logic [SYNC-1:0] dat_q;

  generate
    if (SYNC > 1) begin : g_deep
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          mdc_q <= '0;
          dat_q <= '1;
        end else begin
          mdc_q <= {mdc_q[SYNC-1:0], mdc};
          dat_q <= {dat_q[SYNC-2:0], mdio_in};
        end
      end
    end else begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          mdc_q <= '0;
          dat_q <= '1;
        end else begin
          mdc_q <= {mdc_q[SYNC-1:0], mdc};
          dat_q <= mdio_in;
        end
      end
    end
  endgenerate

  // clock and data pass through equal depths so each sampled bit lines up with its edge
  assign rise  = mdc_q[SYNC-1] & ~mdc_q[SYNC];
  assign bit_q = dat_q[SYNC-1];

endmodule

// File: rtl/mdio_frame_fsm.sv
module mdio_frame_fsm
  import mdio_slv_pkg::*;
#(
  parameter int PAW     = 5,
  parameter int RAW     = 5,
  parameter int DW      = 16,
  parameter int PRE_LEN = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           rise,
  input  logic           bit_in,
  input  logic [PAW-1:0] strap,
  input  logic [DW-1:0]  rd_data,
  output logic [RAW-1:0] rd_addr,
  output logic           wr_en,
  output logic [RAW-1:0] wr_addr,
  output logic [DW-1:0]  wr_data,
  output logic           mdio_out,
  output logic           mdio_oe
);

  localparam int HW = 2 + PAW + RAW;
  localparam int M1 = (PRE_LEN > DW) ? PRE_LEN : DW;
  localparam int M2 = (M1 > HW) ? M1 : HW;
  localparam int CW = $clog2(M2 + 1);
  localparam logic [CW-1:0] PRE_C  = CW'(PRE_LEN);
  localparam logic [CW-1:0] HDR_L  = CW'(HW - 1);
  localparam logic [CW-1:0] DAT_L  = CW'(DW - 1);
  localparam logic [CW-1:0] TA_L   = CW'(1);

  mdio_st_e       st, st_n;
  logic [CW-1:0]  cnt, cnt_n;
  logic [HW-2:0]  hdr, hdr_n;
  logic [HW-1:0]  hdr_full;
  logic [DW-1:0]  dsh, dsh_n;
  logic [RAW-1:0] reg_q, reg_n;
  logic           oe_q, oe_n, out_q, out_n, we_q, we_n;
  logic [1:0]     op_f;
  logic [PAW-1:0] pa_f;

  assign hdr_full = {hdr, bit_in};
  assign op_f     = hdr_full[HW-1 -: 2];
  assign pa_f     = hdr_full[RAW +: PAW];
  assign rd_addr  = hdr_full[RAW-1:0];

  always_comb begin
    st_n  = st;
    cnt_n = cnt;
    hdr_n = hdr;
    dsh_n = dsh;
    reg_n = reg_q;
    oe_n  = oe_q;
    out_n = out_q;
    we_n  = 1'b0;
    if (rise) begin
      case (st)
        S_PRE: begin
          if (bit_in) begin
            if (cnt != PRE_C) cnt_n = cnt + 1'b1;
          end else if (cnt == PRE_C) begin
            st_n  = S_SOF;
            cnt_n = '0;
          end else begin
            cnt_n = '0;
          end
        end
        S_SOF: begin
          cnt_n = '0;
          st_n  = bit_in ? S_CMD : S_PRE;
        end
        S_CMD: begin
          hdr_n = hdr_full[HW-2:0];
          cnt_n = cnt + 1'b1;
          if (cnt == HDR_L) begin
            cnt_n = '0;
            reg_n = hdr_full[RAW-1:0];
            if (pa_f != strap) begin
              st_n = S_PRE;
            end else if (op_f == OP_RD) begin
              st_n  = S_RTA;
              dsh_n = rd_data;
            end else if (op_f == OP_WR) begin
              st_n = S_WTA;
            end else begin
              st_n = S_PRE;
            end
          end
        end
        S_RTA: begin
          oe_n  = 1'b1;
          out_n = 1'b0;
          cnt_n = '0;
          st_n  = S_RDAT;
        end
        S_RDAT: begin
          out_n = dsh[DW-1];
          dsh_n = {dsh[DW-2:0], 1'b0};
          cnt_n = cnt + 1'b1;
          if (cnt == DAT_L) begin
            cnt_n = '0;
            st_n  = S_RLAST;
          end
        end
        S_RLAST: begin
          oe_n  = 1'b0;
          out_n = 1'b0;
          st_n  = S_PRE;
        end
        S_WTA: begin
          cnt_n = cnt + 1'b1;
          if (cnt == TA_L) begin
            cnt_n = '0;
            st_n  = S_WDAT;
          end
        end
        S_WDAT: begin
          dsh_n = {dsh[DW-2:0], bit_in};
          cnt_n = cnt + 1'b1;
          if (cnt == DAT_L) begin
            cnt_n = '0;
            we_n  = 1'b1;
            st_n  = S_PRE;
          end
        end
        default: begin
          st_n  = S_PRE;
          cnt_n = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= S_PRE;
      cnt   <= '0;
      hdr   <= '0;
      dsh   <= '0;
      reg_q <= '0;
      oe_q  <= 1'b0;
      out_q <= 1'b0;
      we_q  <= 1'b0;
    end else begin
      st    <= st_n;
      cnt   <= cnt_n;
      hdr   <= hdr_n;
      dsh   <= dsh_n;
      reg_q <= reg_n;
      oe_q  <= oe_n;
      out_q <= out_n;
      we_q  <= we_n;
    end
  end

  assign wr_en    = we_q;
  assign wr_addr  = reg_q;
  assign wr_data  = dsh;
  assign mdio_out = out_q;
  assign mdio_oe  = oe_q;

  // R4: the pad is only enabled in the read-data phases
  p_oe_read_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mdio_oe |-> (st == S_RDAT || st == S_RLAST));

  // R5: the first driven bit of a read is the turnaround low
  p_ta_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mdio_oe) |-> !mdio_out);

  // R6: line outputs move only after a detected management clock rise
  p_edge_aligned_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !rise |=> ($stable(mdio_oe) && $stable(mdio_out)));

  // R7: a commit is a single-cycle pulse
  p_commit_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !wr_en);

  // R7: no drive while a write is in progress
  p_no_drive_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WTA || st == S_WDAT) |-> !mdio_oe);

endmodule

// File: rtl/mdio_regfile.sv
module mdio_regfile #(
  parameter int RAW = 5,
  parameter int DW  = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           mg_we,
  input  logic [RAW-1:0] mg_waddr,
  input  logic [DW-1:0]  mg_wdata,
  input  logic [RAW-1:0] mg_raddr,
  output logic [DW-1:0]  mg_rdata,
  input  logic           loc_we,
  input  logic [RAW-1:0] loc_addr,
  input  logic [DW-1:0]  loc_wdata,
  output logic [DW-1:0]  loc_rdata
);

  localparam int DEPTH = 1 << RAW;

  logic [DEPTH-1:0][DW-1:0] rows;

  generate
    for (genvar i = 0; i < DEPTH; i++) begin : g_row
      logic [DW-1:0] q;
      logic          hit_mg, hit_loc;
      assign hit_mg  = mg_we  && (mg_waddr == RAW'(i));
      assign hit_loc = loc_we && (loc_addr == RAW'(i));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       q <= '0;
        else if (hit_mg)  q <= mg_wdata;
        else if (hit_loc) q <= loc_wdata;
      end
      assign rows[i] = q;
    end
  endgenerate

  assign mg_rdata  = rows[mg_raddr];
  assign loc_rdata = rows[loc_addr];

  // R8: the management commit survives a same-cycle local write to that entry
  p_mgmt_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mg_we && loc_we && mg_waddr == loc_addr) |=> (rows[$past(mg_waddr)] == $past(mg_wdata)));

endmodule

// File: rtl/mdio_slave.sv
module mdio_slave #(
  parameter int PHY_AW      = 5,
  parameter int REG_AW      = 5,
  parameter int DATA_W      = 16,
  parameter int PRE_LEN     = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mdc,
  input  logic              mdio_in,
  output logic              mdio_out,
  output logic              mdio_oe,
  input  logic [PHY_AW-1:0] phy_addr_strap,
  input  logic [REG_AW-1:0] loc_addr,
  input  logic              loc_we,
  input  logic [DATA_W-1:0] loc_wdata,
  output logic [DATA_W-1:0] loc_rdata
);

  logic [1:0]        rsync;
  logic              rst_i_n;
  logic              rise, bit_q;
  logic [REG_AW-1:0] rd_addr, wr_addr;
  logic [DATA_W-1:0] rd_data, wr_data;
  logic              wr_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync <= '0;
    else        rsync <= {rsync[0], 1'b1};
  end
  assign rst_i_n = rsync[1];

  mdio_sampler #(.SYNC(SYNC_STAGES)) u_smp (
    .clk     (clk),
    .rst_n   (rst_i_n),
    .mdc     (mdc),
    .mdio_in (mdio_in),
    .rise    (rise),
    .bit_q   (bit_q)
  );

  mdio_frame_fsm #(
    .PAW(PHY_AW), .RAW(REG_AW), .DW(DATA_W), .PRE_LEN(PRE_LEN)
  ) u_fsm (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .rise     (rise),
    .bit_in   (bit_q),
    .strap    (phy_addr_strap),
    .rd_data  (rd_data),
    .rd_addr  (rd_addr),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .mdio_out (mdio_out),
    .mdio_oe  (mdio_oe)
  );

  mdio_regfile #(.RAW(REG_AW), .DW(DATA_W)) u_rf (
    .clk       (clk),
    .rst_n     (rst_i_n),
    .mg_we     (wr_en),
    .mg_waddr  (wr_addr),
    .mg_wdata  (wr_data),
    .mg_raddr  (rd_addr),
    .mg_rdata  (rd_data),
    .loc_we    (loc_we),
    .loc_addr  (loc_addr),
    .loc_wdata (loc_wdata),
    .loc_rdata (loc_rdata)
  );

endmodule

// File: tb/mdio_slave_tb.sv
module mdio_slave_tb;

  localparam logic [4:0] STRAP = 5'h0B;

  logic        clk = 1'b0;
  logic        rst_n, mdc, m_en, m_val, coll_drop;
  logic        mdio_out, mdio_oe, line;
  logic [4:0]  loc_addr;
  logic        loc_we;
  logic [15:0] loc_wdata, loc_rdata;
  logic [15:0] model [32];
  int          checks = 0, errors = 0, oe_cnt = 0;

  always #4 clk = ~clk;

  assign line = mdio_oe ? mdio_out : (m_en ? m_val : 1'b1);

  mdio_slave u_dut (
    .clk(clk), .rst_n(rst_n), .mdc(mdc), .mdio_in(line),
    .mdio_out(mdio_out), .mdio_oe(mdio_oe), .phy_addr_strap(STRAP),
    .loc_addr(loc_addr), .loc_we(loc_we), .loc_wdata(loc_wdata), .loc_rdata(loc_rdata)
  );

  always @(posedge clk) if (mdio_oe) oe_cnt++;

  task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one management clock period: low 5 clk, sample at rise, high 5 clk
  task automatic bitc(input logic en, input logic v, output logic s, output logic oe_s);
    @(negedge clk);
    mdc = 1'b0; m_en = en; m_val = v;
    repeat (5) @(negedge clk);
    s = line; oe_s = mdio_oe;
    mdc = 1'b1;
    repeat (4) @(negedge clk);
    if (coll_drop) begin loc_we = 1'b0; coll_drop = 1'b0; end
  endtask

  task automatic drive_bits(input int n, input logic v);
    logic s, o;
    for (int i = 0; i < n; i++) bitc(1'b1, v, s, o);
  endtask

  task automatic frame(input logic [1:0] sof, input logic [1:0] op, input logic [4:0] pa,
                       input logic [4:0] ra, input logic [15:0] wd, input logic is_rd,
                       input logic coll, output logic [15:0] rd,
                       output logic ta1, output logic ta1_oe, output logic ta2, output logic last_oe);
    logic [13:0] hdr;
    logic s, o;
    hdr = {sof, op, pa, ra};
    rd = '0; ta1 = 1'b0; ta1_oe = 1'b0; ta2 = 1'b1; last_oe = 1'b0;
    for (int i = 13; i >= 0; i--) bitc(1'b1, hdr[i], s, o);
    if (is_rd) begin
      bitc(1'b0, 1'b1, ta1, ta1_oe);
      bitc(1'b0, 1'b1, ta2, o);
      for (int i = 15; i >= 0; i--) begin
        bitc(1'b0, 1'b1, s, o);
        rd[i] = s;
        if (i == 0) last_oe = o;
      end
    end else begin
      bitc(1'b1, 1'b1, s, o);
      bitc(1'b1, 1'b0, s, o);
      for (int i = 15; i >= 0; i--) begin
        if (i == 0 && coll) coll_drop = 1'b1;
        bitc(1'b1, wd[i], s, o);
      end
    end
  endtask

  task automatic peek(input logic [4:0] a, output logic [15:0] d);
    @(negedge clk) loc_addr = a;
    @(negedge clk) d = loc_rdata;
  endtask

  task automatic lwrite(input logic [4:0] a, input logic [15:0] d);
    @(negedge clk);
    loc_addr = a; loc_wdata = d; loc_we = 1'b1;
    @(negedge clk) loc_we = 1'b0;
  endtask

  function automatic logic [4:0] other_addr(input logic [4:0] r);
    return STRAP ^ ((r == 5'd0) ? 5'd1 : r);
  endfunction

  task automatic summary;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete");
    summary();
    $finish;
  end

  initial begin
    logic [15:0] d, rd;
    logic t1, t1o, t2, lo, s, o;
    void'($urandom(32'd1357));
    rst_n = 1'b0; mdc = 1'b0; m_en = 1'b0; m_val = 1'b1; coll_drop = 1'b0;
    loc_addr = '0; loc_we = 1'b0; loc_wdata = '0;
    for (int i = 0; i < 32; i++) model[i] = '0;
    repeat (5) @(negedge clk);
    chk(mdio_oe == 1'b0, "R9 oe low in reset", 32'(mdio_oe), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    peek(5'd0, d);  chk(d == 16'h0, "R9 entry 0 after reset", 32'(d), 0);
    peek(5'd31, d); chk(d == 16'h0, "R9 entry 31 after reset", 32'(d), 0);

    // basic write then read back over the link
    oe_cnt = 0;
    drive_bits(32, 1'b1);
    frame(2'b01, 2'b01, STRAP, 5'd5, 16'hA5C3, 1'b0, 1'b0, rd, t1, t1o, t2, lo);
    model[5] = 16'hA5C3;
    peek(5'd5, d); chk(d == 16'hA5C3, "R7 write committed", 32'(d), 32'hA5C3);
    chk(oe_cnt == 0, "R7 no drive on write", 32'(oe_cnt), 0);
    drive_bits(32, 1'b1);
    frame(2'b01, 2'b10, STRAP, 5'd5, 16'h0, 1'b1, 1'b0, rd, t1, t1o, t2, lo);
    chk(t1o == 1'b0 && t1 == 1'b1, "R5 first turnaround released", {t1o, t1}, 32'h1);
    chk(t2 == 1'b0, "R5 second turnaround low", 32'(t2), 0);
    chk(rd == 16'hA5C3, "R6 read data", 32'(rd), 32'hA5C3);
    chk(lo == 1'b1, "R6 oe held through last bit", 32'(lo), 1);
    bitc(1'b0, 1'b1, s, o);
    chk(o == 1'b0, "R6 oe released after last bit", 32'(o), 0);

    // preamble one bit short
    drive_bits(1, 1'b0);
    drive_bits(31, 1'b1);
    frame(2'b01, 2'b01, STRAP, 5'd6, 16'h1234, 1'b0, 1'b0, rd, t1, t1o, t2, lo);
    peek(5'd6, d); chk(d == 16'h0, "R1 short preamble ignored", 32'(d), 0);
    // zero inside the preamble restarts the count
    drive_bits(1, 1'b0);
    drive_bits(20, 1'b1);
    drive_bits(1, 1'b0);
    drive_bits(20, 1'b1);
    frame(2'b01, 2'b01, STRAP, 5'd6, 16'h1234, 1'b0, 1'b0, rd, t1, t1o, t2, lo);
    peek(5'd6, d); chk(d == 16'h0, "R1 broken preamble ignored", 32'(d), 0);
    drive_bits(32, 1'b1);
    frame(2'b01, 2'b01, STRAP, 5'd6, 16'h1234, 1'b0, 1'b0, rd, t1, t1o, t2, lo);
    model[6] = 16'h1234;
    peek(5'd6, d); chk(d == 16'h1234, "R1 full preamble accepted", 32'(d), 32'h1234);

    // malformed start field
    drive_bits(32, 1'b1);
    frame(2'b00, 2'b01, STRAP, 5'd7, 16'hFFFF, 1'b0, 1'b0, rd, t1, t1o, t2, lo);
    peek(5'd7, d); chk(d == 16'h0, "R2 bad start ignored", 32'(d), 0);

    // unknown opcodes
    oe_cnt = 0;
    drive_bits(32, 1'b1);
    frame(2'b01, 2'b11, STRAP, 5'd8, 16'h5555, 1'b0, 1'b0, rd, t1, t1o, t2, lo);
    drive_bits(32, 1'b1);
    frame(2'b01, 2'b00, STRAP, 5'd8, 16'hAAAA, 1'b0, 1'b0, rd, t1, t1o, t2, lo);
    peek(5'd8, d); chk(d == 16'h0, "R3 unknown opcode no write", 32'(d), 0);
    chk(oe_cnt == 0, "R3 unknown opcode no drive", 32'(oe_cnt), 0);

    // device address mismatch
    oe_cnt = 0;
    drive_bits(32, 1'b1);
    frame(2'b01, 2'b01, STRAP ^ 5'h01, 5'd9, 16'h7777, 1'b0, 1'b0, rd, t1, t1o, t2, lo);
    peek(5'd9, d); chk(d == 16'h0, "R4 mismatch write ignored", 32'(d), 0);
    drive_bits(32, 1'b1);
    frame(2'b01, 2'b10, STRAP ^ 5'h10, 5'd5, 16'h0, 1'b1, 1'b0, rd, t1, t1o, t2, lo);
    bitc(1'b0, 1'b1, s, o);
    chk(oe_cnt == 0, "R4 mismatch read never drives", 32'(oe_cnt), 0);

    // local port write seen over the link
    lwrite(5'd10, 16'hBEEF);
    model[10] = 16'hBEEF;
    peek(5'd10, d); chk(d == 16'hBEEF, "R8 local write/read", 32'(d), 32'hBEEF);
    drive_bits(32, 1'b1);
    frame(2'b01, 2'b10, STRAP, 5'd10, 16'h0, 1'b1, 1'b0, rd, t1, t1o, t2, lo);
    chk(rd == 16'hBEEF, "R8 local data read over link", 32'(rd), 32'hBEEF);

    // collision: local write held through the management commit cycle
    drive_bits(32, 1'b1);
    @(negedge clk);
    loc_addr = 5'd11; loc_wdata = 16'hF0F0; loc_we = 1'b1;
    frame(2'b01, 2'b01, STRAP, 5'd11, 16'h0F0F, 1'b0, 1'b1, rd, t1, t1o, t2, lo);
    model[11] = 16'h0F0F;
    peek(5'd11, d); chk(d == 16'h0F0F, "R8 management wins collision", 32'(d), 32'h0F0F);

    // randomized traffic
    for (int n = 0; n < 40; n++) begin
      logic [4:0]  ra, pa;
      logic [15:0] wd;
      logic        is_rd, hit;
      ra = 5'($urandom);
      wd = 16'($urandom);
      is_rd = 1'($urandom);
      hit = ($urandom % 4) != 0;
      pa = hit ? STRAP : other_addr(5'($urandom));
      if (n % 5 == 4) begin
        lwrite(5'(n), wd ^ 16'h3C3C);
        model[5'(n)] = wd ^ 16'h3C3C;
      end
      oe_cnt = 0;
      drive_bits(32, 1'b1);
      frame(2'b01, is_rd ? 2'b10 : 2'b01, pa, ra, wd, is_rd, 1'b0, rd, t1, t1o, t2, lo);
      bitc(1'b0, 1'b1, s, o);
      if (!hit) begin
        chk(oe_cnt == 0, "R4 random mismatch no drive", 32'(oe_cnt), 0);
        peek(ra, d); chk(d == model[ra], "R4 random mismatch no write", 32'(d), 32'(model[ra]));
      end else if (is_rd) begin
        chk(rd == model[ra], "R6 random read data", 32'(rd), 32'(model[ra]));
        chk(t1o == 1'b0 && t2 == 1'b0, "R5 random turnaround", {t1o, t2}, 0);
        chk(o == 1'b0, "R6 random oe release", 32'(o), 0);
      end else begin
        model[ra] = wd;
        peek(ra, d); chk(d == wd, "R7 random write", 32'(d), 32'(wd));
        chk(oe_cnt == 0, "R7 random write no drive", 32'(oe_cnt), 0);
      end
    end

    summary();
    $finish;
  end

endmodule